// File: doc/BRIEF.md
# Run-Length Echo Sequencer

The sequencer watches a one-bit serial stream and measures how long each unbroken stretch of 1s lasts. The first 0 that closes such a stretch starts a playback. In that same clock, and on the clocks right after it, the output gives as many 1s as the stretch was long. At every other time the output stays 0. The length is held in a small up/down counter with an enable. Counting up stops at the counter's all-ones value, so overlong stretches are clipped to the largest value the counter can hold.

A two-state controller steers the counter. Its states are LISTEN and REPLAY. In LISTEN, a 1 on the input makes the counter count up, and the output stays 0. A 0 with a zero count does nothing. A 0 with a count of exactly one gives a single output 1 and stays in LISTEN. A 0 with a count above one gives an output 1 and takes the transition START_REPLAY into REPLAY. In REPLAY the input is not looked at: the counter counts down and the output is 1 on every clock. When the count reaches one, that clock still gives a 1 and the transition END_REPLAY leads back to LISTEN with the counter at zero.

The output depends on the current input as well as on the stored state. The first echoed 1 therefore appears in the same clock as the 0 that ends the stretch.

Top module: `rl_echo_seq`

## Requirements
- R1: After reset the output is 0, the count is 0 and the controller is in LISTEN. A 0 input right after reset gives output 0.
- R2: In LISTEN with input 1, the output is 0 and the count goes up by one each clock.
- R3: The count saturates at 15, the all-ones value of the 4-bit default. A stretch longer than 15 ones is echoed as exactly 15 ones.
- R4: For a stretch of N ones (1 <= N <= 15), the output is 1 in the clock of the closing 0 and in the N-1 clocks that follow. It is 0 in the clock after those.
- R5: In LISTEN, with input 0 and count 0, the output is 0 and nothing changes.
- R6: During REPLAY the input is ignored. Any pattern on the input leaves the number of echoed 1s unchanged and starts no new stretch.
- R7: A REPLAY ends with the count at 0. A 1 on the input in the first clock after the last echoed 1 begins a new stretch, counted from one.
- R8: A stretch of exactly one 1 gives a single output 1 and never enters REPLAY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Serial bit stream being measured |
| echo_out | output | 1 | Echo of the measured stretch length, given as consecutive 1s |

## Verification
The bench goes after the edges of the count range.

- **Stretch of one.** A design that enters REPLAY here would give a second 1.
- **Stretch of 15 and stretches far longer.** A design whose counter wraps would echo a short burst, or none at all.
- **Toggling input during playback.** A design that still listens during REPLAY would stretch or cut the echo.
- **Back-to-back stretches.** A 1 arrives in the first free clock after playback. A design that leaves a stale count, or loses that first bit, would echo the next stretch one too long or one too short.

A seeded random stream with a bias toward long stretches is then checked clock by clock against a separate queue-style reference model.

// File: rtl/rl_echo_pkg.sv
package rl_echo_pkg;

    // Controller states
    typedef enum logic {
        ST_LISTEN = 1'b0,
        ST_REPLAY = 1'b1
    } echo_state_t;

    // Counter command decoded from the controller outputs
    typedef struct packed {
        logic en;
        logic dn;
    } ctr_cmd_t;

endpackage

// File: rtl/rl_updown_ctr.sv
module rl_updown_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dn,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            if (dn) count <= count - 1'b1;
            else    count <= count + 1'b1;
        end
    end

    // R3: controller must never ask for an increment at the top value
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dn) |-> (count != CMAX));

    // R7: controller must never ask for a decrement at zero
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dn) |-> (count != '0));

    // R2: an enabled up step adds exactly one
    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dn) |=> (count == W'($past(count) + 1'b1)));

    // R5: with the enable off the value holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

endmodule

// File: rtl/rl_echo_ctrl.sv
module rl_echo_ctrl
    import rl_echo_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         x,
    input  logic [W-1:0] count,
    output logic         cnt_en,
    output logic         cnt_dn,
    output logic         z
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};
    localparam logic [W-1:0] CONE = {{(W-1){1'b0}}, 1'b1};

    echo_state_t state, state_nx;
    ctr_cmd_t    cmd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LISTEN;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LISTEN: begin
                // START_REPLAY: a closing 0 with more than one 1 counted
                if (!x && (count != '0) && (count != CONE))
                    state_nx = ST_REPLAY;
            end
            ST_REPLAY: begin
                // END_REPLAY: last echoed 1 is being given now
                if (count == CONE)
                    state_nx = ST_LISTEN;
            end
            default: state_nx = ST_LISTEN;
        endcase
    end

    // Outputs (Mealy in LISTEN, Moore in REPLAY)
    always_comb begin
        cmd = '0;
        z   = 1'b0;
        unique case (state)
            ST_LISTEN: begin
                if (x) begin
                    cmd.en = (count != CMAX);
                    cmd.dn = 1'b0;
                end else if (count != '0) begin
                    cmd.en = 1'b1;
                    cmd.dn = 1'b1;
                    z      = 1'b1;
                end
            end
            ST_REPLAY: begin
                cmd.en = 1'b1;
                cmd.dn = 1'b1;
                z      = 1'b1;
            end
            default: ;
        endcase
    end

    assign cnt_en = cmd.en;
    assign cnt_dn = cmd.dn;

    // R6: REPLAY always gives a 1
    a_r6_replay_drives_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY) |-> z);

    // R6: REPLAY stays put regardless of x until the count reaches one
    a_r6_replay_ignores_x: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY && count != CONE) |=> (state == ST_REPLAY));

    // R7: END_REPLAY leaves the counter empty
    a_r7_replay_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY && count == CONE) |=> (state == ST_LISTEN && count == '0));

    // R7: REPLAY is never held with an empty counter
    a_r7_replay_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY) |-> (count != '0));

    // R2: counting in LISTEN is silent
    a_r2_listen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LISTEN && x) |-> !z);

    // R5: idle with empty counter is silent
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LISTEN && !x && count == '0) |-> !z);

    // R8: a single counted 1 never enters REPLAY
    a_r8_single_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LISTEN && !x && count == CONE) |=> (state == ST_LISTEN && count == '0));

endmodule

// File: rtl/rl_echo_seq.sv
module rl_echo_seq #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serial_in,
    output logic echo_out
);
    logic [CNT_W-1:0] run_cnt;
    logic             cnt_en;
    logic             cnt_dn;

    rl_echo_ctrl #(.W(CNT_W)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .x      (serial_in),
        .count  (run_cnt),
        .cnt_en (cnt_en),
        .cnt_dn (cnt_dn),
        .z      (echo_out)
    );

    rl_updown_ctr #(.W(CNT_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .dn    (cnt_dn),
        .count (run_cnt)
    );

    // R1: output is low in the first cycle after reset when input is low
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !serial_in) |-> !echo_out);

endmodule

// File: tb/rl_echo_seq_tb_top.sv
`timescale 1ns/100ps
module rl_echo_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_in = 1'b0;
    logic echo_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int m_run = 0;
    int m_rem = 0;

    always #2.5 clk = ~clk;

    rl_echo_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .serial_in (serial_in),
        .echo_out  (echo_out)
    );

    // Queue-style reference: returns this cycle's expected output
    function automatic bit model_step(bit xv);
        bit e;
        if (m_rem > 0) begin
            e = 1'b1;
            m_rem = m_rem - 1;
        end else if (xv) begin
            e = 1'b0;
            if (m_run < 15) m_run = m_run + 1;
        end else if (m_run > 0) begin
            e = 1'b1;
            m_rem = m_run - 1;
            m_run = 0;
        end else begin
            e = 1'b0;
        end
        return e;
    endfunction

    task automatic check(bit exp, string req);
        checks++;
        if (echo_out !== exp) begin
            errors++;
            $display("FAIL %s: echo_out=%0b expected=%0b at %0t", req, echo_out, exp, $time);
        end
    endtask

    task automatic step(bit xv, string req);
        bit e;
        @(negedge clk);
        serial_in = xv;
        #1;
        e = model_step(xv);
        check(e, req);
    endtask

    task automatic run_of(int n, string req);
        for (int i = 0; i < n; i++) step(1'b1, req);
    endtask

    // count ones given from the closing 0 on, toggling x during playback if asked
    task automatic echo_len(int exp_n, bit wiggle, string req);
        int got = 0;
        bit e;
        @(negedge clk);
        serial_in = 1'b0;
        #1;
        e = model_step(1'b0);
        check(e, req);
        if (echo_out) got++;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            serial_in = wiggle ? (i % 2 == 0) : 1'b0;
            #1;
            e = model_step(serial_in);
            check(e, req);
            if (!echo_out) break;
            got++;
        end
        checks++;
        if (got != exp_n) begin
            errors++;
            $display("FAIL %s: echo length=%0d expected=%0d", req, got, exp_n);
        end
        // flush any stretch the wiggle may have begun after playback
        while (m_run != 0 || m_rem != 0) step(1'b0, req);
    endtask

    initial begin
        rst_n = 1'b0;
        serial_in = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(1'b0, "R1");
        rst_n = 1'b1;
        m_run = 0;
        m_rem = 0;

        step(1'b0, "R1");
        step(1'b0, "R5");
        step(1'b0, "R5");

        // R8: single 1
        run_of(1, "R2");
        echo_len(1, 1'b0, "R8");

        // R4: stretch of 3
        run_of(3, "R2");
        echo_len(3, 1'b0, "R4");

        // R3: stretch of exactly 15, then 22
        run_of(15, "R2");
        echo_len(15, 1'b0, "R3");
        run_of(22, "R3");
        echo_len(15, 1'b0, "R3");

        // R6: input toggling during playback
        run_of(6, "R2");
        echo_len(6, 1'b1, "R6");

        // R7: new stretch right after playback ends
        run_of(4, "R2");
        step(1'b0, "R4");
        step(1'b0, "R6");
        step(1'b0, "R6");
        step(1'b1, "R6");     // last echoed 1, x ignored
        step(1'b1, "R7");     // first free clock: counts as 1
        step(1'b1, "R7");
        echo_len(2, 1'b0, "R7");

        // R4/R6: seeded random stream
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            bit b;
            b = (($urandom % 8) < 5);
            step(b, "R4/R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule